// File: doc/BRIEF.md
# Random Generator Command/Status Controller

This block sits between a 32-bit register port of a host bus and a raw entropy source. The host drives it through one command register: each command is a fixed 32-bit value, and each one is accepted only in the step of a fixed bring-up and delivery sequence where it belongs. Progress is reported through an 8-bit status code. The entropy source supplies 32-bit samples together with a one-cycle valid strobe.

Bring-up follows a fixed order. The host resets the block, releases the reset, enables it and then starts the self-test phase. During that phase a start-up health test watches the incoming samples. It fails on a run of identical samples, and it also fails when too few samples arrive before a cycle deadline. Once the host has seen the pass code it acknowledges it. After that the block captures one entropy word at a time and holds it until the host reads it and acknowledges the read. The host must then re-enable the block before the next word is gathered.

Register map: a write to byte offset 0x0 is a command. A read from offset 0x0 returns the held random word. A read from offset 0x4 returns the status code in bits 7:0, with zeros above.

Top module: `rng_cmd_ctrl`

## Requirements
- R1: After the asynchronous reset, status reads 0x00 with bits 31:8 zero at offset 0x4, and the word at offset 0x0 reads 0.
- R2: Writing 0x00000001 to offset 0x0 in any state makes status read 0xAC from the next cycle on.
- R3: Bring-up commands take effect only in this order: release 0x00000002 after the reset acknowledge, then enable 0x80000000, then zeroize 0x80000004. If one of them arrives out of order it is ignored, and the self-test does not start.
- R4: After zeroize, NEED_SAMPLES valid samples with no run of REP_LIMIT identical consecutive samples give status 0x57. A run one shorter than REP_LIMIT still passes.
- R5: REP_LIMIT identical consecutive valid samples during the self-test give status 0xFA.
- R6: If fewer than NEED_SAMPLES valid samples arrive within TIMEOUT_CYC cycles of zeroize, status becomes 0xFA. Before the deadline it stays 0x00.
- R7: While status is 0xFA, every command except reset is ignored.
- R8: Acknowledge-zeroize 0x80000008 written while status is 0x57 arms capture. The next valid sample is stored, status becomes 0xED, and offset 0x0 returns that sample.
- R9: While status is 0xED, the held word does not change, and further samples are ignored.
- R10: Acknowledge-read 0x8000000F written while status is 0xED drops status to 0x00 on the next cycle. Samples are not captured until enable 0x80000000 is written. After enable, the next valid sample becomes the new word with status 0xED.
- R11: A command value that is not recognised, and any write to offset 0x4, leaves status and word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 32 | Write data (command value) |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| ent_valid | input | 1 | Entropy sample strobe |
| ent_data | input | 32 | Entropy sample |

## Verification
The assertions assume that a write lasts exactly one cycle and that a command and its address are stable while the write strobe is high. They also assume the entropy strobe carries a sample in that same cycle and does not depend on the bus. The bench applies every write and every sample at the falling edge and holds it for one full cycle. It starts feeding entropy only through dedicated tasks, so each sample is placed deliberately relative to the commands. The checker decodes the command values on its own, so a wrong encoding in the decoder shows up as a status mismatch.

// File: rtl/rng_ctrl_pkg.sv
package rng_ctrl_pkg;

  localparam int unsigned WORD_W = 32;

  localparam logic [WORD_W-1:0] CODE_RESET    = 32'h0000_0001;
  localparam logic [WORD_W-1:0] CODE_RELEASE  = 32'h0000_0002;
  localparam logic [WORD_W-1:0] CODE_ENABLE   = 32'h8000_0000;
  localparam logic [WORD_W-1:0] CODE_ZEROIZE  = 32'h8000_0004;
  localparam logic [WORD_W-1:0] CODE_ACK_TEST = 32'h8000_0008;
  localparam logic [WORD_W-1:0] CODE_ACK_WORD = 32'h8000_000F;

  localparam logic [7:0] STAT_IDLE    = 8'h00;
  localparam logic [7:0] STAT_RST_ACK = 8'hAC;
  localparam logic [7:0] STAT_PASS    = 8'h57;
  localparam logic [7:0] STAT_FAIL    = 8'hFA;
  localparam logic [7:0] STAT_NEW     = 8'hED;

  localparam int unsigned OFS_CTRL = 0;
  localparam int unsigned OFS_STAT = 4;

  typedef enum logic [2:0] {
    OP_NONE, OP_RESET, OP_RELEASE, OP_ENABLE, OP_ZEROIZE, OP_ACK_TEST, OP_ACK_WORD
  } op_e;

  typedef enum logic [3:0] {
    ST_OFF, ST_HELD, ST_RELEASED, ST_ENABLED, ST_TESTING,
    ST_PASSED, ST_FAILED, ST_GATHER, ST_READY, ST_DRAINED
  } state_e;

  function automatic logic [7:0] status_of(state_e s);
    case (s)
      ST_HELD:   status_of = STAT_RST_ACK;
      ST_PASSED: status_of = STAT_PASS;
      ST_FAILED: status_of = STAT_FAIL;
      ST_READY:  status_of = STAT_NEW;
      default:   status_of = STAT_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/rng_cmd_decode.sv
module rng_cmd_decode
  import rng_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output op_e               op
);

  always_comb begin
    op = OP_NONE;
    if (wr_en && (addr == ADDR_W'(OFS_CTRL))) begin
      case (wdata)
        CODE_RESET:    op = OP_RESET;
        CODE_RELEASE:  op = OP_RELEASE;
        CODE_ENABLE:   op = OP_ENABLE;
        CODE_ZEROIZE:  op = OP_ZEROIZE;
        CODE_ACK_TEST: op = OP_ACK_TEST;
        CODE_ACK_WORD: op = OP_ACK_WORD;
        default:       op = OP_NONE;
      endcase
    end
  end

endmodule

// File: rtl/rng_startup_test.sv
module rng_startup_test
  import rng_ctrl_pkg::*;
#(
  parameter int unsigned NEED_SAMPLES = 64,
  parameter int unsigned REP_LIMIT    = 8,
  parameter int unsigned TIMEOUT_CYC  = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              ent_valid,
  input  logic [WORD_W-1:0] ent_data,
  output logic              pass_o,
  output logic              fail_o
);

  localparam int unsigned CNT_W = $clog2(NEED_SAMPLES + 1);
  localparam int unsigned RUN_W = $clog2(REP_LIMIT + 1);
  localparam int unsigned TMR_W = $clog2(TIMEOUT_CYC + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [RUN_W-1:0]  run_q;
  logic [TMR_W-1:0]  tmr_q;
  logic [WORD_W-1:0] last_q;
  logic              rep_hit_q;
  logic              enough, timed_out, same;

  assign enough    = (cnt_q == CNT_W'(NEED_SAMPLES));
  assign timed_out = (tmr_q == TMR_W'(TIMEOUT_CYC));
  assign same      = (cnt_q != '0) && (ent_data == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      run_q     <= '0;
      tmr_q     <= '0;
      last_q    <= '0;
      rep_hit_q <= 1'b0;
    end else if (!active) begin
      cnt_q     <= '0;
      run_q     <= '0;
      tmr_q     <= '0;
      rep_hit_q <= 1'b0;
    end else begin
      if (!timed_out) tmr_q <= tmr_q + 1'b1;
      if (ent_valid) begin
        last_q <= ent_data;
        if (!enough) cnt_q <= cnt_q + 1'b1;
        if (same) begin
          if (run_q != RUN_W'(REP_LIMIT)) run_q <= run_q + 1'b1;
          if (run_q == RUN_W'(REP_LIMIT - 1)) rep_hit_q <= 1'b1;
        end else begin
          run_q <= RUN_W'(1);
        end
      end
    end
  end

  assign fail_o = rep_hit_q || (timed_out && !enough);
  assign pass_o = enough && !rep_hit_q;

endmodule

// File: rtl/rng_word_latch.sv
module rng_word_latch
  import rng_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dout <= '0;
    else if (load) dout <= din;
  end

endmodule

// File: rtl/rng_cmd_ctrl.sv
module rng_cmd_ctrl
  import rng_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W       = 4,
  parameter int unsigned NEED_SAMPLES = 64,
  parameter int unsigned REP_LIMIT    = 8,
  parameter int unsigned TIMEOUT_CYC  = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              ent_valid,
  input  logic [31:0]       ent_data
);

  op_e         op;
  state_e      st_q, st_d;
  logic        t_pass, t_fail, t_active, cap_load;
  logic [7:0]  stat_code;
  logic [31:0] held_word;

  rng_cmd_decode #(.ADDR_W(ADDR_W)) u_decode (
    .wr_en (reg_wr_en),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .op    (op)
  );

  assign t_active = (st_q == ST_TESTING);

  rng_startup_test #(
    .NEED_SAMPLES (NEED_SAMPLES),
    .REP_LIMIT    (REP_LIMIT),
    .TIMEOUT_CYC  (TIMEOUT_CYC)
  ) u_health (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (t_active),
    .ent_valid (ent_valid),
    .ent_data  (ent_data),
    .pass_o    (t_pass),
    .fail_o    (t_fail)
  );

  assign cap_load = (st_q == ST_GATHER) && ent_valid && (op != OP_RESET);

  rng_word_latch u_word (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cap_load),
    .din   (ent_data),
    .dout  (held_word)
  );

  always_comb begin
    st_d = st_q;
    if (op == OP_RESET) begin
      st_d = ST_HELD;
    end else begin
      case (st_q)
        ST_HELD:     if (op == OP_RELEASE)  st_d = ST_RELEASED;
        ST_RELEASED: if (op == OP_ENABLE)   st_d = ST_ENABLED;
        ST_ENABLED:  if (op == OP_ZEROIZE)  st_d = ST_TESTING;
        ST_TESTING: begin
          if (t_fail)      st_d = ST_FAILED;
          else if (t_pass) st_d = ST_PASSED;
        end
        ST_PASSED:   if (op == OP_ACK_TEST) st_d = ST_GATHER;
        ST_GATHER:   if (ent_valid)         st_d = ST_READY;
        ST_READY:    if (op == OP_ACK_WORD) st_d = ST_DRAINED;
        ST_DRAINED:  if (op == OP_ENABLE)   st_d = ST_GATHER;
        default:     st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_OFF;
    else        st_q <= st_d;
  end

  assign stat_code = status_of(st_q);

  always_comb begin
    if (reg_addr == ADDR_W'(OFS_CTRL))      reg_rdata = held_word;
    else if (reg_addr == ADDR_W'(OFS_STAT)) reg_rdata = {24'h0, stat_code};
    else                                    reg_rdata = '0;
  end

endmodule

// File: rtl/rng_cmd_ctrl_checker.sv
module rng_cmd_ctrl_checker #(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              ent_valid,
  input logic [7:0]        stat_code,
  input logic [31:0]       held_word
);

  logic ctl_wr, is_reset, is_ack_word, is_new, is_fail;
  assign ctl_wr      = reg_wr_en && (reg_addr == '0);
  assign is_reset    = ctl_wr && (reg_wdata == 32'h0000_0001);
  assign is_ack_word = ctl_wr && (reg_wdata == 32'h8000_000F);
  assign is_new      = (stat_code == 8'hED);
  assign is_fail     = (stat_code == 8'hFA);

  AST_RESET_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    is_reset |=> (stat_code == 8'hAC)); // R2

  AST_FAIL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (is_fail && !is_reset) |=> is_fail); // R7

  AST_NEW_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(is_new) |-> $past(ent_valid)); // R8

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (is_new && $past(is_new)) |-> $stable(held_word)); // R9

  AST_ACK_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    (is_new && is_ack_word) |=> !is_new); // R10

endmodule

bind rng_cmd_ctrl rng_cmd_ctrl_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr_en (reg_wr_en),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .ent_valid (ent_valid),
  .stat_code (stat_code),
  .held_word (held_word)
);

// File: tb/rng_cmd_ctrl_bench.sv
module rng_cmd_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 4;
  localparam int NEED       = 8;
  localparam int REP        = 4;
  localparam int TMO        = 200;

  logic              clk, rst_n, reg_wr_en, ent_valid;
  logic [ADDR_W-1:0] reg_addr;
  logic [31:0]       reg_wdata, reg_rdata, ent_data;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  rng_cmd_ctrl #(
    .ADDR_W(ADDR_W), .NEED_SAMPLES(NEED), .REP_LIMIT(REP), .TIMEOUT_CYC(TMO)
  ) u_rng_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ent_valid(ent_valid), .ent_data(ent_data)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic chk_stat(input string req, input logic [7:0] exp);
    logic [31:0] v;
    rd(4, v);
    chk(req, v, {24'h0, exp});
  endtask

  task automatic chk_word(input string req, input logic [31:0] exp);
    logic [31:0] v;
    rd(0, v);
    chk(req, v, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // kind 0: distinct words, 1: constant word, 2: each word repeated REP-1 times
  task automatic feed(input int kind, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ent_valid = 1;
      case (kind)
        0:       ent_data = 32'h9E37_79B9 * (i + 1) + 32'h1234;
        1:       ent_data = 32'hDEAD_BEEF;
        default: ent_data = 32'h0101_0101 * (i / (REP - 1) + 1);
      endcase
    end
    @(negedge clk);
    ent_valid = 0;
  endtask

  task automatic sample(input logic [31:0] d);
    @(negedge clk);
    ent_valid = 1; ent_data = d;
    @(negedge clk);
    ent_valid = 0;
  endtask

  task automatic start_test();
    wr(0, 32'h0000_0001);
    wr(0, 32'h0000_0002);
    wr(0, 32'h8000_0000);
    wr(0, 32'h8000_0004);
  endtask

  task automatic t_reset_state();
    chk_stat("R1 power-on status", 8'h00);
    chk_word("R1 power-on word", 32'h0);
  endtask

  task automatic t_order();
    wr(0, 32'h8000_0000);
    chk_stat("R3 enable before reset ignored", 8'h00);
    wr(0, 32'h0000_0001);
    chk_stat("R2 reset acknowledged", 8'hAC);
    wr(0, 32'h8000_0004);
    chk_stat("R3 zeroize while held ignored", 8'hAC);
    wr(0, 32'h0000_0002);
    chk_stat("R3 release accepted", 8'h00);
    wr(0, 32'h8000_0004);
    feed(0, 12); idle(3);
    chk_stat("R3 zeroize without enable starts no test", 8'h00);
    wr(0, 32'h8000_0000);
    wr(0, 32'h8000_0004);
    feed(0, 12); idle(3);
    chk_stat("R4 self-test passes", 8'h57);
  endtask

  task automatic t_words();
    start_test();
    feed(2, 12); idle(3);
    chk_stat("R4 run of REP-1 still passes", 8'h57);
    wr(0, 32'h8000_0008);
    chk_stat("R8 armed, no word yet", 8'h00);
    sample(32'hCAFE_0001);
    chk_stat("R8 new word status", 8'hED);
    chk_word("R8 captured word", 32'hCAFE_0001);
    sample(32'hCAFE_0002);
    chk_word("R9 word held against new sample", 32'hCAFE_0001);
    wr(0, 32'h1234_5678);
    chk_stat("R11 unknown command ignored", 8'hED);
    wr(4, 32'h8000_000F);
    chk_stat("R11 write to status offset ignored", 8'hED);
    chk_word("R11 word unchanged", 32'hCAFE_0001);
    wr(0, 32'h8000_000F);
    chk_stat("R10 ack-read drops status", 8'h00);
    sample(32'hCAFE_0003);
    chk_stat("R10 no capture before enable", 8'h00);
    chk_word("R10 word not replaced before enable", 32'hCAFE_0001);
    wr(0, 32'h8000_0000);
    sample(32'hCAFE_0004);
    chk_stat("R10 fresh word status", 8'hED);
    chk_word("R10 fresh word", 32'hCAFE_0004);
    wr(0, 32'h0000_0001);
    chk_stat("R2 reset from new-word state", 8'hAC);
  endtask

  task automatic t_rep_fail();
    start_test();
    feed(1, 6); idle(3);
    chk_stat("R5 repetition fails test", 8'hFA);
    wr(0, 32'h0000_0002);
    wr(0, 32'h8000_0000);
    wr(0, 32'h8000_0004);
    wr(0, 32'h8000_0008);
    feed(0, 4);
    chk_stat("R7 failure ignores non-reset commands", 8'hFA);
    wr(0, 32'h0000_0001);
    chk_stat("R7 reset leaves failure", 8'hAC);
  endtask

  task automatic t_timeout();
    start_test();
    feed(0, NEED - 2);
    idle(TMO / 2 - NEED);
    chk_stat("R6 no result before deadline", 8'h00);
    idle(TMO / 2 + 20);
    chk_stat("R6 starved test fails", 8'hFA);
  endtask

  initial begin
    rst_n = 0; reg_wr_en = 0; reg_addr = '0; reg_wdata = '0;
    ent_valid = 0; ent_data = '0;
    idle(3);
    rst_n = 1;
    idle(1);
    t_reset_state();
    t_order();
    t_words();
    t_rep_fail();
    t_timeout();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule